// File: doc/BRIEF.md
# Serial EEPROM Target with Programming-Cycle Polling

This block is a two-wire bus target that makes a small on-chip byte store look like a serial EEPROM. A system clock oversamples the clock line and the data line. Edge detectors find bus clock edges and the two framing conditions: a Start, where data falls while the clock is high, and a Stop, where data rises while the clock is high. A controller state machine then frames bytes, acknowledges them and moves data. The data line is open-drain. The block only ever pulls it low through `sda_oe`.

A write sends a control byte, one or more address bytes and any number of data bytes. The data bytes collect in a staging buffer. When a Stop closes a write that carried data, a timer models the internal programming time. The staged bytes reach the store only when that time has elapsed. While the timer runs, no byte is acknowledged. Once it ends, the block acknowledges only a control byte equal to the one that opened the write, and that acknowledge clears the poll. A read returns bytes from the address pointer, most significant bit first, until the bus master declines to acknowledge.

States: `ST_IDLE` (ignore bus until Start), `ST_CTRL` (receive control byte), `ST_CTRL_ACK`, `ST_ADDR` (receive address byte), `ST_ADDR_ACK`, `ST_WDATA` (receive data byte), `ST_WDATA_ACK`, `ST_RDATA` (send data byte), `ST_RDATA_ACK` (sample master acknowledge).

Transitions:
- Any state goes to `ST_IDLE` on a Stop, and to `ST_CTRL` on a Start.
- `ST_CTRL` goes to `ST_CTRL_ACK` after eight bits if the byte is accepted; otherwise it goes to `ST_IDLE`.
- `ST_CTRL_ACK` goes to `ST_RDATA` for a read or to `ST_ADDR` for a write.
- `ST_ADDR` goes to `ST_ADDR_ACK`. `ST_ADDR_ACK` goes back to `ST_ADDR` while address bytes remain, then to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, and `ST_WDATA_ACK` returns to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RDATA_ACK`. `ST_RDATA_ACK` goes to `ST_IDLE` on a master NACK, or back to `ST_RDATA` on a master ACK.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A Start moves the block to control-byte reception from any state, and a Stop returns it to idle from any state. Clock pulses seen without a preceding Start are ignored and get no acknowledge.
- R2: The control byte is taken MSB first. Bits 7..1 must equal `DEV_ADDR` (default 7'h50), and bit 0 selects read (1) or write (0). A matching byte is acknowledged. A mismatched byte gets no acknowledge, and later bytes are ignored until the next Start.
- R3: An acknowledge pulls the data line low for the whole high phase of the ninth clock. `sda_oe` changes only while the clock line is low.
- R4: During a write, each address byte (MSB first) loads the address pointer and is acknowledged. Each data byte is acknowledged and staged.
- R5: A Stop after a write that carried at least one data byte starts a programming cycle of `PROG_CYCLES` clocks, and the staged bytes are written when it ends. A Stop after a write that carried only the address starts no cycle.
- R6: While a programming cycle runs, no byte is acknowledged.
- R7: After a cycle ends, control bytes other than the one that opened the write get no acknowledge. The first matching control byte is acknowledged and clears this restriction.
- R8: A read returns the byte at the pointer, MSB first. Each master ACK returns the next byte. The pointer increments and wraps from the last address to 0.
- R9: A master NACK after a read byte leaves `sda_oe` low, releasing the line, until the next Start.
- R10: Consecutive data bytes of one write land at consecutive addresses, wrapping from the last address to 0.
- R11: After reset, `sda_oe` is low and every memory byte reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The assertions assume that the master changes the data line only while the clock line is low, except to form a Start or a Stop. They also assume that every clock phase spans several system clocks, so that the synchronizer sees each edge and each condition separately. The bench's master tasks keep each clock phase at ten system clocks. They move the data line three clocks after a falling clock edge. They create framing conditions only through the dedicated Start and Stop tasks. The master never issues a Stop while the block is driving a zero, which keeps the check that `sda_oe` changes only at a low clock line valid.

// File: rtl/eeprom_i2c_pkg.sv
`timescale 1ns/1ps
package eeprom_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } ee_state_t;

    localparam int BITS_PER_BYTE = 8;

endpackage

// File: rtl/eeprom_line_sampler.sv
`timescale 1ns/1ps
module eeprom_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic scl_m, scl_s, scl_q;
    logic sda_m, sda_s, sda_q;

    // two-flop synchronizer plus one history stage per line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_s <= 1'b1;
            scl_q <= 1'b1;
            sda_m <= 1'b1;
            sda_s <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_m <= scl_i;
            scl_s <= scl_m;
            scl_q <= scl_s;
            sda_m <= sda_i;
            sda_s <= sda_m;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_lvl   = scl_s;
        sda_lvl   = sda_s;
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
        start_evt = scl_s && scl_q && sda_q && !sda_s;
        stop_evt  = scl_s && scl_q && !sda_q && sda_s;
    end

endmodule

// File: rtl/eeprom_prog_timer.sv
`timescale 1ns/1ps
module eeprom_prog_timer #(
    parameter int CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            busy   <= 1'b0;
        end else if (start && !busy) begin
            remain <= CW'(CYCLES);
            busy   <= 1'b1;
        end else if (busy) begin
            remain <= remain - 1'b1;
            if (remain == CW'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign done = busy && (remain == CW'(1));

endmodule

// File: rtl/eeprom_store.sv
`timescale 1ns/1ps
module eeprom_store #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [7:0]        push_data,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              staged_any
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PIDX_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam int CNT_W  = $clog2(PAGE_BYTES + 1);

    logic [7:0]        mem   [DEPTH];
    logic [7:0]        stage [PAGE_BYTES];
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  count;
    logic [PIDX_W-1:0] widx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'h00;
            end
            for (int j = 0; j < PAGE_BYTES; j++) begin
                stage[j] <= 8'h00;
            end
            base  <= '0;
            count <= '0;
            widx  <= '0;
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (j < int'(count)) begin
                    mem[base + ADDR_W'(j)] <= stage[j];
                end
            end
            count <= '0;
            widx  <= '0;
        end else if (clear) begin
            count <= '0;
            widx  <= '0;
        end else if (push) begin
            if (count == '0) begin
                base <= push_addr;
            end
            stage[widx] <= push_data;
            widx        <= (int'(widx) == PAGE_BYTES - 1) ? '0 : widx + 1'b1;
            if (int'(count) < PAGE_BYTES) begin
                count <= count + 1'b1;
            end
        end
    end

    assign rd_data    = mem[rd_addr];
    assign staged_any = (count != '0);

endmodule

// File: rtl/eeprom_i2c_target.sv
`timescale 1ns/1ps
module eeprom_i2c_target
    import eeprom_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 8,
    parameter int         PAGE_BYTES  = 8,
    parameter int         PROG_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
    localparam int AB_W       = ADDR_BYTES * 8;
    localparam int AL_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic busy, prog_done, prog_start;
    logic staged_any, stage_push, stage_clear, load_rd;
    logic [7:0] rd_data;

    ee_state_t st, st_nxt;

    logic [3:0]        cnt;
    logic [7:0]        rxb;
    logic [7:0]        shreg;
    logic              rw_q;
    logic [7:0]        cur_ctrl;
    logic [7:0]        poll_ctrl;
    logic              poll_pending;
    logic [AB_W-1:0]   abuf;
    logic [AB_W-1:0]   abuf_nxt;
    logic [AL_W-1:0]   addr_left;
    logic              a_done;
    logic [ADDR_W-1:0] ptr;
    logic              byte_end;
    logic              ctrl_ok;

    eeprom_line_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    eeprom_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy),
        .done  (prog_done)
    );

    eeprom_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (stage_clear),
        .push       (stage_push),
        .push_addr  (ptr),
        .push_data  (rxb),
        .commit     (prog_done),
        .rd_addr    (ptr),
        .rd_data    (rd_data),
        .staged_any (staged_any)
    );

    // decode of events against the current state
    always_comb begin
        byte_end    = scl_fall && (cnt == 4'(BITS_PER_BYTE));
        ctrl_ok     = !busy && (rxb[7:1] == DEV_ADDR) &&
                      (!poll_pending || (rxb == poll_ctrl));
        stage_push  = (st == ST_WDATA) && byte_end;
        stage_clear = (st == ST_CTRL) && byte_end && ctrl_ok;
        load_rd     = scl_fall && (((st == ST_CTRL_ACK) && rw_q) || (st == ST_RDATA_ACK));
        prog_start  = stop_evt && staged_any &&
                      ((st == ST_WDATA) || (st == ST_WDATA_ACK));
        abuf_nxt    = (abuf << 8) | AB_W'(rxb);
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        if (stop_evt) begin
            st_nxt = ST_IDLE;
        end else if (start_evt) begin
            st_nxt = ST_CTRL;
        end else begin
            unique case (st)
                ST_IDLE:      st_nxt = ST_IDLE;
                ST_CTRL:      if (byte_end) st_nxt = ctrl_ok ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK:  if (scl_fall) st_nxt = rw_q ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (byte_end) st_nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall) st_nxt = a_done ? ST_WDATA : ST_ADDR;
                ST_WDATA:     if (byte_end) st_nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) st_nxt = ST_WDATA;
                ST_RDATA:     if (byte_end) st_nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: begin
                    if (scl_rise && sda_lvl) begin
                        st_nxt = ST_IDLE;
                    end else if (scl_fall) begin
                        st_nxt = ST_RDATA;
                    end
                end
                default:      st_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt          <= '0;
            rxb          <= '0;
            shreg        <= '0;
            rw_q         <= 1'b0;
            cur_ctrl     <= '0;
            poll_ctrl    <= '0;
            poll_pending <= 1'b0;
            abuf         <= '0;
            addr_left    <= '0;
            a_done       <= 1'b0;
            ptr          <= '0;
        end else begin
            if (start_evt || stop_evt) begin
                cnt <= '0;
            end else begin
                case (st)
                    ST_CTRL, ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            rxb <= {rxb[6:0], sda_lvl};
                            cnt <= cnt + 1'b1;
                        end else if (byte_end) begin
                            cnt <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == 4'(BITS_PER_BYTE)) begin
                                cnt <= '0;
                            end else begin
                                shreg <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                    default: ;
                endcase
            end

            if ((st == ST_CTRL) && byte_end) begin
                rw_q      <= rxb[0];
                cur_ctrl  <= rxb;
                addr_left <= AL_W'(ADDR_BYTES - 1);
                a_done    <= 1'b0;
            end

            if (prog_start) begin
                poll_pending <= 1'b1;
                poll_ctrl    <= cur_ctrl;
            end else if (stage_clear) begin
                poll_pending <= 1'b0;
            end

            if ((st == ST_ADDR) && byte_end) begin
                abuf <= abuf_nxt;
                if (addr_left == '0) begin
                    ptr    <= abuf_nxt[ADDR_W-1:0];
                    a_done <= 1'b1;
                end else begin
                    addr_left <= addr_left - 1'b1;
                end
            end

            if (stage_push) begin
                ptr <= ptr + 1'b1;
            end

            if (load_rd) begin
                shreg <= rd_data;
                ptr   <= ptr + 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        unique case (st)
            ST_CTRL_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                               sda_oe = !shreg[7];
            default:                                sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/eeprom_i2c_target_chk.sv
`timescale 1ns/1ps
module eeprom_i2c_target_chk
    import eeprom_i2c_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sda_oe,
    input logic      scl_lvl,
    input logic      start_evt,
    input logic      stop_evt,
    input logic      busy,
    input ee_state_t st
);

    assert_oe_quiet_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    assert_oe_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_lvl));

    assert_stop_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (st == ST_IDLE));

    assert_start_to_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (st == ST_CTRL));

    assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_lvl   (scl_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .busy      (busy),
    .st        (st)
);

// File: tb/eeprom_i2c_target_tb_top.sv
`timescale 1ns/1ps
module eeprom_i2c_target_tb_top;

    localparam int PROG = 3000;
    localparam int H    = 10;
    localparam int Q    = 3;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   cyc = 0;

    assign sda_line = sda_m & ~sda_oe;

    eeprom_i2c_target #(.PROG_CYCLES(PROG)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    int    checks = 0;
    int    errors = 0;
    int    exp_q[$];
    string tag_q[$];
    int    obs_q[$];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input string tag, input int v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    // monitor: pairs each observation with the oldest expectation
    initial begin
        int    v;
        int    e;
        string t;
        forever begin
            wait (obs_q.size() != 0);
            v = obs_q.pop_front();
            if (exp_q.size() == 0) begin
                chk("unexpected observation", v, -1);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, v, e);
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1;
        tick(Q);
        scl_m = 1'b1;
        tick(H);
        sda_m = 1'b0;
        tick(H);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b1;
        tick(H);
        sda_m = 1'b1;
        tick(H);
    endtask

    // ack result: 1 = ACK held, 0 = NACK, 2 = level changed during high phase
    task automatic send_byte(input logic [7:0] b, input bit track, output int ack);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            tick(H - Q);
            scl_m = 1'b1;
            tick(H);
            scl_m = 1'b0;
            tick(Q);
        end
        sda_m = 1'b1;
        tick(H - Q);
        scl_m = 1'b1;
        tick(2);
        a1 = ~sda_line;
        tick(H - 4);
        a2 = ~sda_line;
        tick(2);
        scl_m = 1'b0;
        tick(Q);
        ack = (a1 == a2) ? int'(a1) : 2;
        if (track) obs_q.push_back(ack);
    endtask

    task automatic send_t(input logic [7:0] b);
        int a;
        send_byte(b, 1'b1, a);
    endtask

    task automatic read_byte(input bit give_ack);
        logic [7:0] v;
        v = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(H - Q);
            scl_m = 1'b1;
            tick(H / 2);
            v = {v[6:0], sda_line};
            tick(H / 2);
            scl_m = 1'b0;
            tick(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        tick(H - Q);
        scl_m = 1'b1;
        tick(H);
        scl_m = 1'b0;
        tick(Q);
        sda_m = 1'b1;
        obs_q.push_back(int'(v));
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int a;
        int polls;
        int t0;
        int elapsed;

        tick(5);
        chk("R11 sda_oe during reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(5);
        chk("R11 sda_oe after reset", int'(sda_oe), 0);

        // clocks without a Start
        scl_m = 1'b0;
        tick(H);
        expect_item("R1 byte without start", 0);
        send_t(8'hA0);
        bus_stop();

        // wrong device address, then a further byte
        bus_start();
        expect_item("R2 mismatched device", 0);
        send_t(8'hB0);
        expect_item("R2 byte after mismatch", 0);
        send_t(8'h10);
        bus_stop();

        // write three bytes at 0x10
        bus_start();
        expect_item("R2 matching write control", 1);
        send_t(8'hA0);
        expect_item("R3/R4 address ack", 1);
        send_t(8'h10);
        expect_item("R4 data ack 0", 1);
        send_t(8'h11);
        expect_item("R4 data ack 1", 1);
        send_t(8'h22);
        expect_item("R4 data ack 2", 1);
        send_t(8'h33);
        bus_stop();

        // cycle running
        bus_start();
        expect_item("R6 poll during cycle", 0);
        send_t(8'hA0);
        bus_stop();

        tick(PROG);
        bus_start();
        expect_item("R7 other control after cycle", 0);
        send_t(8'hA1);
        bus_stop();
        bus_start();
        expect_item("R7 matching poll after cycle", 1);
        send_t(8'hA0);
        bus_stop();

        // address-only write starts no cycle; current-address read
        bus_start();
        expect_item("R5 control for address-only", 1);
        send_t(8'hA0);
        expect_item("R5 address-only address", 1);
        send_t(8'h10);
        bus_stop();
        bus_start();
        expect_item("R5 no cycle after address-only", 1);
        send_t(8'hA1);
        expect_item("R8 read byte 0x10", 8'h11);
        read_byte(1'b1);
        expect_item("R8 read byte 0x11", 8'h22);
        read_byte(1'b1);
        expect_item("R8 read byte 0x12", 8'h33);
        read_byte(1'b0);
        tick(2);
        chk("R9 released after NACK", int'(sda_oe), 0);
        tick(H);
        chk("R9 still released", int'(sda_oe), 0);
        bus_stop();

        // wrapping write
        bus_start();
        expect_item("R10 control", 1);
        send_t(8'hA0);
        expect_item("R10 address FE", 1);
        send_t(8'hFE);
        expect_item("R10 data FE", 1);
        send_t(8'hA1);
        expect_item("R10 data FF", 1);
        send_t(8'hB2);
        expect_item("R10 data 00", 1);
        send_t(8'hC3);
        bus_stop();
        t0 = cyc;

        polls = 0;
        a = 0;
        while (a != 1 && polls < 60) begin
            bus_start();
            send_byte(8'hA0, 1'b0, a);
            polls++;
            elapsed = cyc - t0;
            bus_stop();
        end
        chk("R5 poll eventually acked", a, 1);
        chk("R5 several polls refused", int'(polls > 1), 1);
        chk("R5 cycle not shorter than PROG", int'(elapsed >= PROG - 20), 1);
        chk("R5 cycle not much longer than PROG", int'(elapsed <= PROG + 400), 1);

        // random read across the wrap
        bus_start();
        expect_item("R8 dummy write control", 1);
        send_t(8'hA0);
        expect_item("R8 dummy write address", 1);
        send_t(8'hFE);
        bus_start();
        expect_item("R8 read control after repeated start", 1);
        send_t(8'hA1);
        expect_item("R10 byte at FE", 8'hA1);
        read_byte(1'b1);
        expect_item("R10 byte at FF", 8'hB2);
        read_byte(1'b1);
        expect_item("R10 byte at 00 after wrap", 8'hC3);
        read_byte(1'b1);
        expect_item("R11 untouched byte at 01", 8'h00);
        read_byte(1'b0);
        bus_stop();

        tick(20);
        wait (obs_q.size() == 0);
        tick(2);
        if (exp_q.size() != 0) begin
            chk("missing observations", 0, exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule